// File: doc/BRIEF.md
# Data-Strobe Transmit Serializer Encoder

This block turns parallel words from a link-layer interface into an outbound serial stream carried on two lines, a data line and a strobe line. The strobe line changes only in a bit slot where the data line keeps its level. Each system-clock period the block takes one word, if one is offered. A speed selector sets how many of the parallel lines that word uses: 2, 4 or 8. The bits of the word go out most significant first, in evenly spaced bit slots of a fast clock.

The whole block runs on the fast clock, which runs at eight times the system-clock rate. An internal phase counter marks each system-clock boundary with `word_req`. The source presents a word with `in_valid` in the cycle where `word_req` is high. The word and its speed are captured at that edge and then feed the following window of eight fast cycles. Each updated bit slot is flagged on `ser_valid`. When no word is offered, both lines hold their levels. A receiver recovers the bit clock as the XOR of the two lines.

Top module: `ds_tx_serializer`

## Requirements
- R1: After reset is released, `ser_data`, `ser_strobe` and `ser_valid` are 0, and `word_req` is high in the first cycle.
- R2: `word_req` is high for exactly one fast-clock cycle in every 8, one system-clock period apart.
- R3: Speed code 2'b00 sends 2 bits per word taken from `in_data[7:6]`. Code 2'b01 sends 4 bits from `in_data[7:4]`. Code 2'b10 sends all 8 bits `in_data[7:0]`. Code 2'b11 behaves like 2'b00.
- R4: The word, its valid flag and its speed are captured only at the clock edge where `word_req` is high. Changes to `in_data` and `in_speed` at any other time have no effect on the output stream.
- R5: Within each word, bits are sent most significant first, and `ser_data` equals the bit of the current slot. Consecutive valid words form one unbroken stream.
- R6: Slots of a word are evenly spaced in its window. At speed 2'b10 there is a slot every fast cycle, at 2'b01 every 2nd cycle, and at 2'b00 or 2'b11 every 4th cycle. `ser_valid` is high for one cycle for each updated slot.
- R7: In an updated slot, `ser_strobe` becomes the inverse of its previous value when the new data bit equals the previous data bit; otherwise it keeps its value.
- R8: In every updated slot, exactly one of `ser_data` and `ser_strobe` changes, so their XOR toggles once per slot.
- R9: While no valid word is in flight, `ser_valid` stays 0 and both serial lines hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock, 8 cycles per system-clock period |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A word is offered in this word_req cycle |
| in_speed | input | 2 | Speed code: 00 = 2 bits, 01 = 4 bits, 10 = 8 bits, 11 = 2 bits |
| in_data | input | LANES | Parallel data lines; the used lines are the upper ones |
| word_req | output | 1 | System-clock boundary; a word offered now is captured |
| ser_data | output | 1 | Encoded data line |
| ser_strobe | output | 1 | Encoded strobe line |
| ser_valid | output | 1 | The serial lines were updated in this slot |

## Verification
The assertions check the following on every cycle. Each updated slot changes exactly one line and copies the shifted bit. Both lines hold when nothing is in flight. Each capture edge latches the offered valid flag and top bit. Each system-clock window has the number of slots its latched speed calls for. Only the bench scenarios can show that the recovered bit order matches the words at every speed code, including the alias code. They also show that words with mixed speeds stay contiguous, that input changes between capture edges are ignored, and that the strobe follows the encoding rule across runs of equal and alternating bits.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

  localparam int unsigned SHIFT_W = 2;

  // Log2 of the slot spacing for a speed code; also log2(LANES / bits per word).
  function automatic logic [SHIFT_W-1:0] spd_shift(input logic [1:0] code);
    case (code)
      2'b01:   spd_shift = 2'd1;
      2'b10:   spd_shift = 2'd0;
      default: spd_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/ds_tx_timing.sv
module ds_tx_timing
  import ds_tx_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SHIFT_W-1:0] sh_q,
  output logic               word_req,
  output logic               slot
);

  localparam int unsigned PW = $clog2(LANES);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] step_mask;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + 1'b1;
  end

  assign step_mask = PW'((1 << sh_q) - 1);
  assign word_req  = (phase_q == '0);
  assign slot      = ((phase_q & step_mask) == '0);

  // Slot counter used only by the window check below.
  logic [PW:0] slot_cnt_q;
  logic        win_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_cnt_q <= '0;
      win_ok_q   <= 1'b0;
    end else if (word_req) begin
      slot_cnt_q <= '0;
      win_ok_q   <= 1'b1;
    end else if (slot) begin
      slot_cnt_q <= slot_cnt_q + 1'b1;
    end
  end

  AST_SLOTS_PER_WINDOW: assert property (@(posedge clk) disable iff (rst || !win_ok_q)
    word_req |-> (int'(slot_cnt_q) + 1 == int'(LANES >> sh_q))); // R6

  AST_WORD_REQ_PERIOD: assert property (@(posedge clk) disable iff (rst)
    word_req |=> !word_req); // R2

endmodule

// File: rtl/ds_tx_shifter.sv
module ds_tx_shifter
  import ds_tx_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               slot,
  input  logic               in_valid,
  input  logic [1:0]         in_speed,
  input  logic [LANES-1:0]   in_data,
  output logic               busy,
  output logic               cur_bit,
  output logic [SHIFT_W-1:0] sh_q
);

  logic [LANES-1:0] shreg_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      busy_q  <= 1'b0;
      sh_q    <= spd_shift(2'b00);
    end else if (load) begin
      shreg_q <= in_data;
      busy_q  <= in_valid;
      sh_q    <= spd_shift(in_speed);
    end else if (slot) begin
      shreg_q <= {shreg_q[LANES-2:0], 1'b0};
    end
  end

  assign busy    = busy_q;
  assign cur_bit = shreg_q[LANES-1];

  AST_WORD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    load |=> (busy_q == $past(in_valid)) && (cur_bit == $past(in_data[LANES-1]))); // R4

  AST_MSB_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (slot && !load) |=> (cur_bit == $past(shreg_q[LANES-2]))); // R5

endmodule

// File: rtl/ds_tx_encoder.sv
module ds_tx_encoder (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic bit_in,
  output logic d_q,
  output logic s_q,
  output logic v_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q <= 1'b0;
      s_q <= 1'b0;
      v_q <= 1'b0;
    end else begin
      v_q <= fire;
      if (fire) begin
        d_q <= bit_in;
        if (bit_in == d_q) s_q <= ~s_q;
      end
    end
  end

  AST_RESET_LINES: assert property (@(posedge clk)
    rst |=> (!d_q && !s_q && !v_q)); // R1

  AST_ONE_LINE_MOVES: assert property (@(posedge clk) disable iff (rst)
    fire |=> ((d_q != $past(d_q)) != (s_q != $past(s_q)))); // R8

  AST_DATA_TRACKS_BIT: assert property (@(posedge clk) disable iff (rst)
    fire |=> (d_q == $past(bit_in))); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(d_q) && $stable(s_q) && !v_q)); // R9

endmodule

// File: rtl/ds_tx_serializer.sv
module ds_tx_serializer
  import ds_tx_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_speed,
  input  logic [LANES-1:0] in_data,
  output logic             word_req,
  output logic             ser_data,
  output logic             ser_strobe,
  output logic             ser_valid
);

  logic               slot;
  logic               busy;
  logic               cur_bit;
  logic [SHIFT_W-1:0] sh_q;

  ds_tx_timing #(.LANES(LANES)) u_timing (
    .clk      (clk),
    .rst      (rst),
    .sh_q     (sh_q),
    .word_req (word_req),
    .slot     (slot)
  );

  ds_tx_shifter #(.LANES(LANES)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (word_req),
    .slot     (slot),
    .in_valid (in_valid),
    .in_speed (in_speed),
    .in_data  (in_data),
    .busy     (busy),
    .cur_bit  (cur_bit),
    .sh_q     (sh_q)
  );

  ds_tx_encoder u_enc (
    .clk    (clk),
    .rst    (rst),
    .fire   (slot && busy),
    .bit_in (cur_bit),
    .d_q    (ser_data),
    .s_q    (ser_strobe),
    .v_q    (ser_valid)
  );

endmodule

// File: tb/ds_tx_serializer_test.sv
module ds_tx_serializer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_speed = 2'b00;
  logic [7:0] in_data = 8'h00;
  logic       word_req, ser_data, ser_strobe, ser_valid;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic exp_bits [0:1023];
  logic rx_bits  [0:1023];
  int   exp_n = 0;
  int   rx_n = 0;
  int   gap = 0;
  int   gap_step = 0;
  logic gap_chk = 1'b0;
  logic pd = 1'b0;
  logic ps = 1'b0;

  ds_tx_serializer #(.LANES(8)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_speed(in_speed),
    .in_data(in_data), .word_req(word_req), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .ser_valid(ser_valid)
  );

  always #10 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int step_of(input logic [1:0] s);
    case (s)
      2'b01:   return 2;
      2'b10:   return 1;
      default: return 4;
    endcase
  endfunction

  // Slot-level monitor: encoding rule, one-line change, spacing, hold while idle.
  always @(negedge clk) begin
    if (rst) begin
      pd <= 1'b0; ps <= 1'b0; gap <= 0;
    end else if (ser_valid) begin
      check(((ser_data != pd) != (ser_strobe != ps)), "R8 one line moves", int'({ser_data, ser_strobe}), int'({pd, ps}));
      check(ser_strobe == ((ser_data == pd) ? ~ps : ps), "R7 strobe rule", int'(ser_strobe), int'((ser_data == pd) ? ~ps : ps));
      if (gap_chk && rx_n > 0)
        check(gap == gap_step, "R6 slot spacing", gap, gap_step);
      if (rx_n < 1024) rx_bits[rx_n] = ser_data;
      rx_n = rx_n + 1;
      pd <= ser_data; ps <= ser_strobe; gap <= 1;
    end else begin
      if (ser_data != pd || ser_strobe != ps)
        check(1'b0, "R9 lines hold", int'({ser_data, ser_strobe}), int'({pd, ps}));
      gap <= gap + 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_req();
    @(negedge clk);
    while (!word_req) @(negedge clk);
  endtask

  // Offer one word at a capture edge, then scramble inputs mid-window (R4).
  task automatic put_word(input logic [1:0] spd, input logic [7:0] d);
    int n;
    wait_req();
    in_valid = 1'b1; in_speed = spd; in_data = d;
    n = 8 / step_of(spd);
    for (int i = 0; i < n; i++) begin
      exp_bits[exp_n] = d[7-i];
      exp_n++;
    end
    @(negedge clk);
    in_data = ~d; in_speed = spd + 2'd1;
  endtask

  task automatic go_idle();
    wait_req();
    in_valid = 1'b0; in_data = 8'h5A; in_speed = 2'b10;
    repeat (20) @(negedge clk);
  endtask

  task automatic start_run(input int step, input logic chk);
    go_idle();
    exp_n = 0; rx_n = 0; gap_step = step; gap_chk = chk;
  endtask

  task automatic compare(input string req);
    check(rx_n == exp_n, req, rx_n, exp_n);
    for (int i = 0; i < exp_n && i < rx_n; i++)
      if (rx_bits[i] !== exp_bits[i]) begin
        check(1'b0, req, int'(rx_bits[i]), int'(exp_bits[i]));
        return;
      end
    check(1'b1, req, 0, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(ser_data == 1'b0 && ser_strobe == 1'b0 && ser_valid == 1'b0, "R1 reset lines", int'({ser_data, ser_strobe, ser_valid}), 0);
    check(word_req == 1'b1, "R1 first word_req", int'(word_req), 1);
  endtask

  task automatic t_word_req_period();
    int last, n;
    last = -1; n = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (word_req) begin
        if (last >= 0) check(c - last == 8, "R2 word_req period", c - last, 8);
        last = c; n++;
      end
    end
    check(n == 5, "R2 word_req count", n, 5);
  endtask

  task automatic t_speed(input logic [1:0] spd, input string req);
    logic [7:0] pat [0:5];
    pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'hFF;
    pat[3] = 8'h00; pat[4] = 8'h96; pat[5] = 8'h4B;
    start_run(step_of(spd), 1'b1);
    for (int i = 0; i < 6; i++) put_word(spd, pat[i]);
    go_idle();
    compare(req);
  endtask

  task automatic t_runs();
    start_run(1, 1'b1);
    put_word(2'b10, 8'h00);
    put_word(2'b10, 8'h00);
    put_word(2'b10, 8'hFF);
    put_word(2'b10, 8'h55);
    put_word(2'b10, 8'hAA);
    go_idle();
    compare("R7 equal and alternating runs");
  endtask

  task automatic t_mixed();
    start_run(1, 1'b0);
    put_word(2'b10, 8'hC3);
    put_word(2'b00, 8'h80);
    put_word(2'b01, 8'h70);
    put_word(2'b11, 8'h40);
    put_word(2'b10, 8'h1E);
    go_idle();
    compare("R4 per-word speed capture");
  endtask

  task automatic t_idle_gaps();
    int seen;
    start_run(2, 1'b0);
    put_word(2'b01, 8'hB0);
    go_idle();
    seen = rx_n;
    // Inputs wiggle with in_valid low across several windows.
    for (int i = 0; i < 4; i++) begin
      wait_req();
      in_valid = 1'b0; in_data = 8'(i * 37); in_speed = 2'(i);
    end
    repeat (10) @(negedge clk);
    check(rx_n == seen, "R9 no slots while idle", rx_n, seen);
    put_word(2'b01, 8'h60);
    go_idle();
    compare("R9 stream resumes after idle");
  endtask

  initial begin
    t_reset();
    t_word_req_period();
    t_speed(2'b00, "R3 speed 00 two bits");
    t_speed(2'b01, "R3 speed 01 four bits");
    t_speed(2'b10, "R5 speed 10 msb first");
    t_speed(2'b11, "R3 speed 11 alias");
    t_runs();
    t_mixed();
    t_idle_gaps();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule